// File: doc/BRIEF.md
# Chained Two-Buffer Event Readout Sequencer

This block is the front-end half of an event readout exchange with a data collector. It watches an asynchronous trigger line. When the trigger falls, the block reports that it takes part in the event and asks for readout of its first buffer. It also watches a validation strobe, and on that strobe's falling edge it captures a small event number from the collector.

The block then drains two 32-bit, show-ahead word buffers, one after the other. Each word is offered to the collector with a ready flag. The flag stays up until the collector acknowledges the word. Only then does the block pop that word from its buffer. When the first buffer runs dry, the block drops the first start request and raises a link flag, which acts as the start request for the second buffer. When the second buffer runs dry, it raises the final end flag toward the collector. A reject from the collector, or an acknowledge that does not arrive in time, cuts the readout short. The collector's completion reset returns everything to idle.

Filling the buffers is done elsewhere. The block only reads them through their empty flags, head words and pop strobes.

Top module: `rdo_readout_seq`

## Requirements
- R1: After reset, val_ack_o, start_ro_o, link_end_o, end_ro_o, ready_o, pop0_o and pop1_o are all 0 and evnum_o is 0.
- R2: A high-to-low transition on trig_in while idle sets val_ack_o and start_ro_o to 1, with end_ro_o at 0, within four clock cycles.
- R3: A high-to-low transition on valid_in loads evnum_in into evnum_o. A change of evnum_in without such a transition, or a low-to-high transition of valid_in, leaves evnum_o unchanged.
- R4: Each word is shown on data_o with ready_o at 1 and stays unchanged until ack_in is seen. In the cycle after the acknowledge, ready_o is 0 and exactly one pop strobe of the active buffer pulses. Words leave in buffer order.
- R5: When buffer 0 is empty, start_ro_o goes to 0 and link_end_o goes to 1. Buffer 1 is then served, using pop1_o only and never pop0_o.
- R6: When buffer 1 is empty, end_ro_o goes to 1 with ready_o at 0.
- R7: If ready_o stays 1 for TMO_CYCLES cycles with no acknowledge, the readout aborts. ready_o, start_ro_o and link_end_o go to 0, end_ro_o goes to 1, and the word is not popped.
- R8: reject_in at 1 during an active readout aborts it at the next edge, with the same outputs as R7, and no further pops follow.
- R9: done_rst_in at 1 clears val_ack_o, start_ro_o, link_end_o and end_ro_o and returns to idle, after which a new trigger is accepted.
- R10: A trigger fall during an active readout has no effect on val_ack_o, start_ro_o, link_end_o, ready_o or data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_in | input | 1 | Asynchronous trigger; its falling edge starts an event |
| valid_in | input | 1 | Asynchronous validation strobe; its falling edge captures the event number |
| evnum_in | input | EVW | Event number offered by the collector |
| reject_in | input | 1 | Collector reject, aborts an active readout |
| done_rst_in | input | 1 | Collector completion reset |
| ack_in | input | 1 | Collector word acknowledge |
| fifo0_empty_i | input | 1 | Buffer 0 empty flag |
| fifo0_data_i | input | DW | Buffer 0 head word |
| fifo1_empty_i | input | 1 | Buffer 1 empty flag |
| fifo1_data_i | input | DW | Buffer 1 head word |
| val_ack_o | output | 1 | Event participation flag |
| start_ro_o | output | 1 | Readout request for buffer 0 |
| link_end_o | output | 1 | End of buffer 0, start request for buffer 1 |
| end_ro_o | output | 1 | Final end of readout to the collector |
| ready_o | output | 1 | Word on data_o is valid |
| data_o | output | DW | Word offered to the collector |
| evnum_o | output | EVW | Captured event number |
| pop0_o | output | 1 | Pop strobe for buffer 0 |
| pop1_o | output | 1 | Pop strobe for buffer 1 |

## Verification
The readout is run with several fill patterns: both buffers holding words, buffer 0 empty with buffer 1 full, buffer 0 full with buffer 1 empty, and both empty. These patterns separate a correct chain hand-over from one that skips a stage, serves the wrong buffer, or stalls on an empty one. The acknowledge is held back on purpose to show that a word is not popped early, and a second trigger arrives mid-readout to show that it is ignored. Separate runs end early through a reject and through an expired acknowledge wait, and the timing of end_ro_o is checked against the timeout length.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_WAIT,
      PH_SHOW,
      PH_POP,
      PH_DONE
   } rdo_phase_t;

   localparam int unsigned RDO_BUFS = 2;
endpackage

// File: rtl/rdo_edge_sync.sv
module rdo_edge_sync #(
   parameter int unsigned STAGES   = 2,
   parameter bit          FALL_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic fall_o
);
   localparam int unsigned TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("rdo_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sq;
   logic              last_q;
   logic              fall_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq     <= '0;
         last_q <= 1'b0;
      end else begin
         sq     <= {sq[STAGES-2:0], d_async};
         last_q <= sq[TOP];
      end
   end

   assign fall_raw = last_q & ~sq[TOP];

   if (FALL_REG) begin : g_reg
      logic fall_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) fall_q <= 1'b0;
         else        fall_q <= fall_raw;
      end
      assign fall_o = fall_q;
   end else begin : g_comb
      assign fall_o = fall_raw;
   end
endmodule

// File: rtl/rdo_timeout.sv
module rdo_timeout #(
   parameter int unsigned LIMIT = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic ack_i,
   output logic expire_o
);
   localparam int unsigned CW = $clog2(LIMIT + 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("rdo_timeout: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (run_i && !ack_i) cnt_q <= cnt_q + 1'b1;
      else                      cnt_q <= '0;
   end

   assign expire_o = run_i && !ack_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/rdo_chain_fsm.sv
module rdo_chain_fsm
   import rdo_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         trig_fall_i,
   input  logic                         reject_i,
   input  logic                         done_rst_i,
   input  logic                         ack_i,
   input  logic                         tmo_i,
   input  logic [RDO_BUFS-1:0]          empty_i,
   input  logic [RDO_BUFS-1:0][DW-1:0]  data_i,
   output logic                         val_ack_o,
   output logic                         start_o,
   output logic                         link_o,
   output logic                         end_o,
   output logic                         ready_o,
   output logic [DW-1:0]                data_o,
   output logic [RDO_BUFS-1:0]          pop_o,
   output logic                         show_o
);
   rdo_phase_t          phase_q;
   logic                sel_q;
   logic                abort;
   logic [DW-1:0]       data_q;
   logic [RDO_BUFS-1:0] pop_q;

   always_comb begin
      abort = 1'b0;
      unique case (phase_q)
         PH_WAIT, PH_POP: abort = reject_i;
         PH_SHOW:         abort = reject_i || tmo_i;
         default:         abort = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         sel_q     <= 1'b0;
         val_ack_o <= 1'b0;
         start_o   <= 1'b0;
         link_o    <= 1'b0;
         end_o     <= 1'b0;
         ready_o   <= 1'b0;
         data_q    <= '0;
         pop_q     <= '0;
      end else begin
         pop_q <= '0;
         if (done_rst_i) begin
            phase_q   <= PH_IDLE;
            sel_q     <= 1'b0;
            val_ack_o <= 1'b0;
            start_o   <= 1'b0;
            link_o    <= 1'b0;
            end_o     <= 1'b0;
            ready_o   <= 1'b0;
         end else if (abort) begin
            phase_q <= PH_DONE;
            start_o <= 1'b0;
            link_o  <= 1'b0;
            end_o   <= 1'b1;
            ready_o <= 1'b0;
         end else begin
            unique case (phase_q)
               PH_IDLE: begin
                  if (trig_fall_i) begin
                     val_ack_o <= 1'b1;
                     start_o   <= 1'b1;
                     sel_q     <= 1'b0;
                     phase_q   <= PH_WAIT;
                  end
               end
               PH_WAIT: begin
                  if (!empty_i[sel_q]) begin
                     data_q  <= data_i[sel_q];
                     ready_o <= 1'b1;
                     phase_q <= PH_SHOW;
                  end else if (!sel_q) begin
                     start_o <= 1'b0;
                     link_o  <= 1'b1;
                     sel_q   <= 1'b1;
                  end else begin
                     end_o   <= 1'b1;
                     phase_q <= PH_DONE;
                  end
               end
               PH_SHOW: begin
                  if (ack_i) begin
                     ready_o      <= 1'b0;
                     pop_q[sel_q] <= 1'b1;
                     phase_q      <= PH_POP;
                  end
               end
               PH_POP:  phase_q <= PH_WAIT;
               default: phase_q <= phase_q;
            endcase
         end
      end
   end

   assign data_o = data_q;
   assign pop_o  = pop_q;
   assign show_o = (phase_q == PH_SHOW);
endmodule

// File: rtl/rdo_readout_seq.sv
module rdo_readout_seq
   import rdo_pkg::*;
#(
   parameter int unsigned DW          = 32,
   parameter int unsigned EVW         = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TMO_CYCLES  = 256
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           trig_in,
   input  logic           valid_in,
   input  logic [EVW-1:0] evnum_in,
   input  logic           reject_in,
   input  logic           done_rst_in,
   input  logic           ack_in,
   input  logic           fifo0_empty_i,
   input  logic [DW-1:0]  fifo0_data_i,
   input  logic           fifo1_empty_i,
   input  logic [DW-1:0]  fifo1_data_i,
   output logic           val_ack_o,
   output logic           start_ro_o,
   output logic           link_end_o,
   output logic           end_ro_o,
   output logic           ready_o,
   output logic [DW-1:0]  data_o,
   output logic [EVW-1:0] evnum_o,
   output logic           pop0_o,
   output logic           pop1_o
);
   if (DW < 1 || EVW < 1) begin : g_bad_width
      $error("rdo_readout_seq: widths must be positive");
   end

   logic                        trig_fall;
   logic                        valid_fall;
   logic                        tmo;
   logic                        show;
   logic [RDO_BUFS-1:0]         empty_v;
   logic [RDO_BUFS-1:0][DW-1:0] data_v;
   logic [RDO_BUFS-1:0]         pop_v;
   logic [EVW-1:0]              evnum_q;

   assign empty_v   = {fifo1_empty_i, fifo0_empty_i};
   assign data_v[0] = fifo0_data_i;
   assign data_v[1] = fifo1_data_i;

   rdo_edge_sync #(.STAGES(SYNC_STAGES), .FALL_REG(1'b0)) u_trig_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (trig_in),
      .fall_o  (trig_fall)
   );

   rdo_edge_sync #(.STAGES(SYNC_STAGES), .FALL_REG(1'b0)) u_valid_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (valid_in),
      .fall_o  (valid_fall)
   );

   rdo_timeout #(.LIMIT(TMO_CYCLES)) u_tmo (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (show),
      .ack_i    (ack_in),
      .expire_o (tmo)
   );

   rdo_chain_fsm #(.DW(DW)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_fall_i (trig_fall),
      .reject_i    (reject_in),
      .done_rst_i  (done_rst_in),
      .ack_i       (ack_in),
      .tmo_i       (tmo),
      .empty_i     (empty_v),
      .data_i      (data_v),
      .val_ack_o   (val_ack_o),
      .start_o     (start_ro_o),
      .link_o      (link_end_o),
      .end_o       (end_ro_o),
      .ready_o     (ready_o),
      .data_o      (data_o),
      .pop_o       (pop_v),
      .show_o      (show)
   );

   // R3: event number is taken only on the synchronised falling strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          evnum_q <= '0;
      else if (valid_fall) evnum_q <= evnum_in;
   end

   assign evnum_o = evnum_q;
   assign pop0_o  = pop_v[0];
   assign pop1_o  = pop_v[1];
endmodule

// File: rtl/rdo_readout_seq_chk.sv
module rdo_readout_seq_chk #(
   parameter int unsigned DW         = 32,
   parameter int unsigned TMO_CYCLES = 256
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reject_in,
   input logic          done_rst_in,
   input logic          ack_in,
   input logic          val_ack_o,
   input logic          start_ro_o,
   input logic          link_end_o,
   input logic          end_ro_o,
   input logic          ready_o,
   input logic [DW-1:0] data_o,
   input logic          pop0_o,
   input logic          pop1_o
);
   localparam int unsigned CW = $clog2(TMO_CYCLES + 2);

   logic [CW-1:0] ready_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ready_run <= '0;
      else if (ready_o && !ack_in) ready_run <= ready_run + 1'b1;
      else                         ready_run <= '0;
   end

   p_valack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ro_o || link_end_o) |-> val_ack_o);

   p_ready_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !ack_in && !reject_in && !done_rst_in) |=> (ready_o || end_ro_o));

   p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !ack_in) |=> (!ready_o || $stable(data_o)));

   p_pop_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop0_o || pop1_o) |-> $past(ready_o && ack_in));

   p_pop_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pop0_o, pop1_o}));

   p_chain_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_ro_o && link_end_o));

   p_pop1_linked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pop1_o |-> link_end_o);

   p_end_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      end_ro_o |-> (!ready_o && !start_ro_o));

   p_tmo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (ready_run < CW'(TMO_CYCLES)));

   p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((start_ro_o || link_end_o) && !end_ro_o && reject_in && !done_rst_in)
      |=> (end_ro_o && !start_ro_o && !link_end_o && !ready_o));

   p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_rst_in |=> (!val_ack_o && !end_ro_o && !link_end_o));
endmodule

bind rdo_readout_seq rdo_readout_seq_chk #(.DW(DW), .TMO_CYCLES(TMO_CYCLES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reject_in   (reject_in),
   .done_rst_in (done_rst_in),
   .ack_in      (ack_in),
   .val_ack_o   (val_ack_o),
   .start_ro_o  (start_ro_o),
   .link_end_o  (link_end_o),
   .end_ro_o    (end_ro_o),
   .ready_o     (ready_o),
   .data_o      (data_o),
   .pop0_o      (pop0_o),
   .pop1_o      (pop1_o)
);

// File: tb/rdo_readout_seq_test.sv
`timescale 1ns/1ps
module rdo_readout_seq_test;
   localparam int TMO = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_in = 1'b1;
   logic        valid_in = 1'b1;
   logic [3:0]  evnum_in = 4'h0;
   logic        reject_in = 1'b0;
   logic        done_rst_in = 1'b0;
   logic        ack_in = 1'b0;
   logic        fifo0_empty, fifo1_empty;
   logic [31:0] fifo0_data, fifo1_data;
   logic        val_ack_o, start_ro_o, link_end_o, end_ro_o, ready_o;
   logic [31:0] data_o;
   logic [3:0]  evnum_o;
   logic        pop0_o, pop1_o;

   int checks = 0;
   int fails  = 0;

   logic [31:0] m0 [16];
   logic [31:0] m1 [16];
   int wr0 = 0, rd0 = 0, wr1 = 0, rd1 = 0;
   logic flush = 1'b0;

   always #4 clk = ~clk;

   assign fifo0_empty = (rd0 == wr0);
   assign fifo1_empty = (rd1 == wr1);
   assign fifo0_data  = m0[rd0[3:0]];
   assign fifo1_data  = m1[rd1[3:0]];

   always @(posedge clk) begin
      if (flush) begin
         rd0 <= wr0;
         rd1 <= wr1;
      end else begin
         if (pop0_o) rd0 <= rd0 + 1;
         if (pop1_o) rd1 <= rd1 + 1;
      end
   end

   rdo_readout_seq #(.DW(32), .EVW(4), .SYNC_STAGES(2), .TMO_CYCLES(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .valid_in(valid_in),
      .evnum_in(evnum_in), .reject_in(reject_in), .done_rst_in(done_rst_in),
      .ack_in(ack_in), .fifo0_empty_i(fifo0_empty), .fifo0_data_i(fifo0_data),
      .fifo1_empty_i(fifo1_empty), .fifo1_data_i(fifo1_data),
      .val_ack_o(val_ack_o), .start_ro_o(start_ro_o), .link_end_o(link_end_o),
      .end_ro_o(end_ro_o), .ready_o(ready_o), .data_o(data_o), .evnum_o(evnum_o),
      .pop0_o(pop0_o), .pop1_o(pop1_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic fill(input int buf_id, input int n, input logic [31:0] base);
      for (int i = 0; i < n; i++) begin
         if (buf_id == 0) begin m0[wr0 % 16] = base + i; wr0++; end
         else             begin m1[wr1 % 16] = base + i; wr1++; end
      end
   endtask

   task automatic wait_ready(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 30 && !seen; i++) begin
         @(negedge clk);
         if (ready_o) seen = 1'b1;
      end
   endtask

   task automatic do_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
   endtask

   task automatic fire_trig();
      @(negedge clk); trig_in = 1'b0;
      repeat (3) @(negedge clk);
      chk(val_ack_o == 1'b1, "R2", "val_ack after trigger", val_ack_o, 1);
      chk(start_ro_o == 1'b1 && end_ro_o == 1'b0, "R2", "start/end after trigger",
          {start_ro_o, end_ro_o}, 2'b10);
      trig_in = 1'b1;
   endtask

   task automatic collector_done();
      @(negedge clk); done_rst_in = 1'b1;
      @(negedge clk); done_rst_in = 1'b0;
      chk(!val_ack_o && !start_ro_o && !link_end_o && !end_ro_o, "R9", "flags after completion reset",
          {val_ack_o, start_ro_o, link_end_o, end_ro_o}, 0);
   endtask

   // one word from buffer b, value exp; optionally holds ack back and re-triggers first
   task automatic take_word(input int b, input logic [31:0] exp, input bit hold, input bit retrig);
      bit seen;
      wait_ready(seen);
      chk(seen, "R4", "ready for word", seen, 1);
      if (!seen) return;
      chk(data_o == exp, "R4", "word order/value", data_o, exp);
      if (b == 1)
         chk(link_end_o && !start_ro_o, "R5", "buffer 1 served after link", {link_end_o, start_ro_o}, 2'b10);
      if (hold) begin
         repeat (2) @(negedge clk);
         chk(ready_o && data_o == exp && !pop0_o && !pop1_o, "R4", "held word without ack",
             data_o, exp);
      end
      if (retrig) begin
         trig_in = 1'b0;
         repeat (5) @(negedge clk);
         trig_in = 1'b1;
         chk(val_ack_o && start_ro_o && !link_end_o && ready_o && data_o == exp, "R10",
             "retrigger ignored", {val_ack_o, start_ro_o, link_end_o, ready_o}, 4'b1101);
      end
      ack_in = 1'b1;
      @(negedge clk);
      ack_in = 1'b0;
      chk(!ready_o, "R4", "ready drops after ack", ready_o, 0);
      if (b == 0) chk(pop0_o && !pop1_o, "R4", "pop0 pulse", {pop0_o, pop1_o}, 2'b10);
      else        chk(pop1_o && !pop0_o, "R5", "pop1 pulse only", {pop0_o, pop1_o}, 2'b01);
   endtask

   task automatic run_event(input int n0, input int n1, input logic [31:0] base, input bit extra);
      bit fin;
      fill(0, n0, base);
      fill(1, n1, base + 32'h100);
      fire_trig();
      for (int i = 0; i < n0; i++) take_word(0, base + i, extra && i == 0, extra && i == 0);
      for (int i = 0; i < n1; i++) take_word(1, base + 32'h100 + i, 1'b0, 1'b0);
      fin = 1'b0;
      for (int i = 0; i < 20 && !fin; i++) begin
         @(negedge clk);
         if (end_ro_o) fin = 1'b1;
      end
      chk(fin && !ready_o, "R6", "final end after buffer 1 empty", {fin, ready_o}, 2'b10);
      chk(link_end_o && !start_ro_o, "R5", "link flag kept at end", {link_end_o, start_ro_o}, 2'b10);
      collector_done();
   endtask

   task automatic test_reset();
      chk(!val_ack_o && !start_ro_o && !link_end_o && !end_ro_o && !ready_o && !pop0_o && !pop1_o,
          "R1", "outputs after reset",
          {val_ack_o, start_ro_o, link_end_o, end_ro_o, ready_o, pop0_o, pop1_o}, 0);
      chk(evnum_o == 4'h0, "R1", "event number after reset", evnum_o, 0);
   endtask

   task automatic test_evnum();
      @(negedge clk); evnum_in = 4'h5; valid_in = 1'b0;
      repeat (4) @(negedge clk);
      chk(evnum_o == 4'h5, "R3", "event number on strobe fall", evnum_o, 4'h5);
      evnum_in = 4'h9; valid_in = 1'b1;
      repeat (5) @(negedge clk);
      chk(evnum_o == 4'h5, "R3", "no capture without fall", evnum_o, 4'h5);
      evnum_in = 4'hA; valid_in = 1'b0;
      repeat (4) @(negedge clk);
      chk(evnum_o == 4'hA, "R3", "second capture", evnum_o, 4'hA);
      valid_in = 1'b1;
   endtask

   task automatic test_reject();
      bit seen;
      int rd_snap;
      fill(0, 2, 32'h0000_0A00);
      fill(1, 2, 32'h0000_0B00);
      fire_trig();
      take_word(0, 32'h0000_0A00, 1'b0, 1'b0);
      wait_ready(seen);
      reject_in = 1'b1;
      @(negedge clk);
      reject_in = 1'b0;
      chk(end_ro_o && !start_ro_o && !link_end_o && !ready_o && !pop0_o, "R8", "abort on reject",
          {end_ro_o, start_ro_o, link_end_o, ready_o, pop0_o}, 5'b10000);
      rd_snap = rd0 + rd1;
      repeat (6) @(negedge clk);
      chk(rd0 + rd1 == rd_snap && !ready_o, "R8", "no pops after reject", rd0 + rd1, rd_snap);
      collector_done();
      do_flush();
   endtask

   task automatic test_timeout();
      bit seen;
      int rd_snap;
      fill(0, 1, 32'h0000_0C00);
      fire_trig();
      wait_ready(seen);
      rd_snap = rd0;
      repeat (TMO - 1) @(negedge clk);
      chk(ready_o && !end_ro_o, "R7", "still waiting before limit", {ready_o, end_ro_o}, 2'b10);
      @(negedge clk);
      chk(!ready_o && end_ro_o && !start_ro_o && !link_end_o, "R7", "abort at limit",
          {ready_o, end_ro_o, start_ro_o, link_end_o}, 4'b0100);
      repeat (3) @(negedge clk);
      chk(rd0 == rd_snap, "R7", "timed-out word not popped", rd0, rd_snap);
      collector_done();
      do_flush();
   endtask

   initial begin
      #(8 * 50000);
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_evnum();
      run_event(3, 2, 32'h1000_0000, 1'b1);
      run_event(0, 3, 32'h2000_0000, 1'b0);
      run_event(2, 0, 32'h3000_0000, 1'b0);
      run_event(0, 0, 32'h4000_0000, 1'b0);
      test_reject();
      test_timeout();
      run_event(1, 1, 32'h5000_0000, 1'b0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule